// File: doc/BRIEF.md
# Memory-Mapped General Purpose I/O Port Block

This block gives a small processor bus access to 32 general purpose pins grouped into four 8-bit ports. Three ports are bidirectional: each has an output data latch and a direction register, and each pin drives a separate output value and output enable. A tristate pad outside the block combines them. The fourth port is input-only. Bit 6 of that port is also sent unchanged to the interrupt logic as a second external interrupt source.

Software writes the direction register to choose which pins drive. It writes the data latch to set the driven values. When a data register is read, each bit comes from one of two places. An output bit returns what was written to its latch. An input bit returns the level sampled at the pin.

The direction registers are write-only and read back as all ones. The output latches have no reset, so software should load them before turning any pin into an output.

Top module: `gpio_port_block`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), every direction bit is 0, so `pin_oe` is all zeros and every pin is an input.
- R2: A write to a direction register (0x004 for port 0, 0x005 for port 1, 0x006 for port 2) takes effect at that clock edge. Each 1 bit sets the matching `pin_oe` bit (port k owns pins 8k..8k+7), and each 0 bit clears it.
- R3: A write to a data register (0x000, 0x001, 0x002 for ports 0, 1, 2) loads all eight latch bits at that clock edge, whatever the direction bits are. The latch appears on the port's `pin_out` slice.
- R4: Reading a bidirectional data register returns, bit by bit, the latch where the direction bit is 1 and `pin_in` where it is 0.
- R5: Reading any direction register address returns 0xFF.
- R6: Reading address 0x003 returns `pin_in[31:24]`. A write to 0x003 changes no latch and no direction bit.
- R7: `irq2_raw` equals `pin_in[30]` (bit 6 of the input-only port) combinationally.
- R8: A read of any address other than 0x000 to 0x006 returns 0x00. A write to such an address changes no latch and no direction bit.
- R9: `bus_rdata` is 0x00 whenever `bus_rd` is low.
- R10: Registers hold their value across cycles with no write to their address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 12 | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_rd | input | 1 | Read strobe, qualifies combinational read data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| pin_in | input | 32 | Pin levels, port k on bits 8k..8k+7, input-only port on 31:24 |
| pin_out | output | 24 | Output values of the three bidirectional ports |
| pin_oe | output | 24 | Output enables, 1 = pin drives |
| irq2_raw | output | 1 | Raw copy of input-only port bit 6 |

## Verification
Writes are due one edge after the strobe. The bench drives each write on the falling edge and checks `pin_out` and `pin_oe` at the next falling edge, after the register has taken the data.

Reads and `irq2_raw` have no register in their path. Their checks run a short delay after the address, strobe and pins change, within the same cycle.

The expected latch and direction state comes from a model in the bench, which is updated only for writes to mapped addresses. The random phase mixes writes to the input-only port and to unmapped addresses with the mapped ones, so any stray update shows up as a mismatch.

// File: rtl/gpio_pkg.sv
// Shared constants for the GPIO port block: register address codes.
// Assumes a flat byte address space starting at zero.
package gpio_pkg;
    localparam int unsigned DATA_BASE = 0;   // data reg of port k at DATA_BASE + k
    localparam int unsigned IN_ADDR   = 3;   // input-only port data address
    localparam int unsigned DIR_BASE  = 4;   // direction reg of port k at DIR_BASE + k
    localparam int unsigned IRQ_BIT   = 6;   // input-only bit forwarded to interrupts
endpackage

// File: rtl/gpio_bus_decode.sv
// Address decoder: converts bus address and strobes into one-hot register selects.
// Assumes full address compare; anything not matched is unmapped.
module gpio_bus_decode
    import gpio_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int N_BIDIR = 3
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr,
    output logic [N_BIDIR-1:0] hit_data,
    output logic [N_BIDIR-1:0] hit_dir,
    output logic               hit_in,
    output logic [N_BIDIR-1:0] wr_data,
    output logic [N_BIDIR-1:0] wr_dir
);
    genvar k;
    generate
        for (k = 0; k < N_BIDIR; k++) begin : g_sel
            // per-port compare of data and direction addresses
            assign hit_data[k] = (addr == ADDR_W'(DATA_BASE + k));
            assign hit_dir[k]  = (addr == ADDR_W'(DIR_BASE + k));
            assign wr_data[k]  = wr & hit_data[k];
            assign wr_dir[k]   = wr & hit_dir[k];
        end
    endgenerate

    // input-only port address match
    assign hit_in = (addr == ADDR_W'(IN_ADDR));
endmodule

// File: rtl/gpio_bidir_port.sv
// One bidirectional port: unreset output latch, resettable direction register,
// and a per-bit read mux (latch for outputs, pin for inputs).
// Assumes write enables are already qualified by the decoder.
module gpio_bidir_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_data,
    input  logic         wr_dir,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_lvl,
    output logic [W-1:0] out_val,
    output logic [W-1:0] out_en,
    output logic [W-1:0] rd_val
);
    logic [W-1:0] latch_q;
    logic [W-1:0] dir_q;

    // output latch: loaded by every data write, never reset
    always_ff @(posedge clk) begin
        if (wr_data) latch_q <= wdata;
    end

    // direction register: cleared by reset, loaded by direction writes
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= '0;
        else if (wr_dir) dir_q <= wdata;
    end

    // read value: latch on output bits, pin level on input bits
    always_comb begin
        rd_val = (latch_q & dir_q) | (pin_lvl & ~dir_q);
    end

    assign out_val = latch_q;
    assign out_en  = dir_q;

    AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> out_en == $past(wdata)); // R2
    AST_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> out_val == $past(wdata)); // R3
    AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_dir && $past(rst_n)) |=> $stable(out_en)); // R10
endmodule

// File: rtl/gpio_port_block.sv
// GPIO port block top: three bidirectional ports plus one input-only port
// behind a small synchronous register bus with combinational read data.
// Assumes pads combine pin_out/pin_oe externally; pin_in is already synchronised.
module gpio_port_block
    import gpio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [11:0] bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic [31:0] pin_in,
    output logic [23:0] pin_out,
    output logic [23:0] pin_oe,
    output logic        irq2_raw
);
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 12;
    localparam int N_BIDIR = 3;
    localparam int IN_LSB  = N_BIDIR * DATA_W;

    logic [N_BIDIR-1:0] hit_data, hit_dir, wr_data, wr_dir;
    logic               hit_in;
    logic [DATA_W-1:0]  rd_val [N_BIDIR];

    gpio_bus_decode #(.ADDR_W(ADDR_W), .N_BIDIR(N_BIDIR)) u_dec (
        .addr     (bus_addr),
        .wr       (bus_wr),
        .hit_data (hit_data),
        .hit_dir  (hit_dir),
        .hit_in   (hit_in),
        .wr_data  (wr_data),
        .wr_dir   (wr_dir)
    );

    genvar k;
    generate
        for (k = 0; k < N_BIDIR; k++) begin : g_port
            gpio_bidir_port #(.W(DATA_W)) u_port (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_data (wr_data[k]),
                .wr_dir  (wr_dir[k]),
                .wdata   (bus_wdata),
                .pin_lvl (pin_in[k*DATA_W +: DATA_W]),
                .out_val (pin_out[k*DATA_W +: DATA_W]),
                .out_en  (pin_oe[k*DATA_W +: DATA_W]),
                .rd_val  (rd_val[k])
            );
        end
    endgenerate

    // read mux: qualified by bus_rd, unmapped addresses give zero
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (hit_in) bus_rdata = pin_in[IN_LSB +: DATA_W];
            for (int i = 0; i < N_BIDIR; i++) begin
                if (hit_data[i]) bus_rdata = rd_val[i];
                if (hit_dir[i])  bus_rdata = '1;
            end
        end
    end

    // second interrupt source taken straight from the input-only port
    assign irq2_raw = pin_in[IN_LSB + IRQ_BIT];

    AST_RESET_INPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> pin_oe == '0); // R1
    AST_DIR_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr >= 12'd4 && bus_addr <= 12'd6) |-> bus_rdata == 8'hFF); // R5
    AST_INPORT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 12'd3) |-> bus_rdata == pin_in[31:24]); // R6
    AST_INPORT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 12'd3) |=> ($stable(pin_oe) && $stable(pin_out))); // R6
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr > 12'd6) |-> bus_rdata == 8'h00); // R8
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> bus_rdata == 8'h00); // R9
endmodule

// File: tb/tb_gpio_port_block.sv
module tb_gpio_port_block;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [31:0] pin_in = '0;
    logic [23:0] pin_out;
    logic [23:0] pin_oe;
    logic        irq2_raw;

    int n_checks = 0;
    int n_errors = 0;
    logic [7:0] m_lat [3];
    logic [7:0] m_dir [3];
    logic       lat_known = 1'b0;

    gpio_port_block dut (.*);

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [11:0] a, input logic [31:0] pins);
        if (a <= 12'd2) return (m_lat[a] & m_dir[a]) | (pins[a*8 +: 8] & ~m_dir[a]);
        if (a == 12'd3) return pins[31:24];
        if (a <= 12'd6) return 8'hFF;
        return 8'h00;
    endfunction

    // write at falling edge, edge captures, model updated, outputs checked next fall
    task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a <= 12'd2) m_lat[a] = d;
        else if (a >= 12'd4 && a <= 12'd6) m_dir[a-4] = d;
        chk("R2/R6/R8 oe", pin_oe, {m_dir[2], m_dir[1], m_dir[0]});
        if (lat_known) chk("R3/R6/R8 out", pin_out, {m_lat[2], m_lat[1], m_lat[0]});
    endtask

    task automatic bus_read(input logic [11:0] a, input string req);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        chk(req, bus_rdata, exp_read(a, pin_in));
        chk("R7 irq2", irq2_raw, pin_in[30]);
        bus_rd = 1'b0;
        #1;
        chk("R9 idle", bus_rdata, 8'h00);
    endtask

    initial begin
        #300000;
        n_errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 3; i++) begin m_dir[i] = 8'h00; m_lat[i] = 8'h00; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        chk("R1 reset oe", pin_oe, 24'h0);
        // R4 all inputs: data reads follow pins
        pin_in = 32'hA5C3_7E19;
        bus_read(12'd0, "R4 input read p0");
        bus_read(12'd2, "R4 input read p2");
        // R3 latch written while pins are inputs
        lat_known = 1'b1;
        bus_write(12'd0, 8'h3C);
        bus_write(12'd1, 8'hF0);
        bus_write(12'd2, 8'h81);
        // R2 mixed direction
        bus_write(12'd4, 8'h0F);
        bus_write(12'd5, 8'hFF);
        bus_read(12'd0, "R4 mixed read p0");
        bus_read(12'd1, "R4 output read p1");
        bus_read(12'd5, "R5 dir read");
        bus_read(12'd6, "R5 dir read zero dir");
        // R6 input-only port write ignored, read returns pins
        bus_write(12'd3, 8'h55);
        bus_read(12'd3, "R6 inport read");
        // R8 unmapped
        bus_write(12'd7, 8'hAA);
        bus_write(12'hFFF, 8'h11);
        bus_read(12'd7, "R8 unmapped read");
        bus_read(12'h800, "R8 unmapped read high");
        // R10 hold over idle cycles
        repeat (5) @(negedge clk);
        chk("R10 hold oe", pin_oe, {m_dir[2], m_dir[1], m_dir[0]});
        chk("R10 hold out", pin_out, {m_lat[2], m_lat[1], m_lat[0]});
        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [11:0] a;
            a = ($urandom % 4 == 0) ? 12'($urandom) : 12'($urandom % 8);
            pin_in = $urandom;
            if ($urandom % 2) bus_write(a, 8'($urandom));
            else bus_read(a, "R4/R5/R6/R8 random read");
        end
        // R1 reset again mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 3; i++) m_dir[i] = 8'h00;
        chk("R1 second reset oe", pin_oe, 24'h0);
        chk("R1 latch kept", pin_out, {m_lat[2], m_lat[1], m_lat[0]});
        bus_read(12'd1, "R4 after reset read");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule